// File: doc/BRIEF.md
# Subranging Staircase Converter Sequencer

This block is the digital side of a counting analogue-to-digital converter that splits each measurement into a coarse pass and a fine pass. It drives a 16-bit code to an external DAC and reads one comparator bit. The comparator bit is high when the DAC output is at or above the held sample. The upper byte of the code rises in steps, each worth 256 fine steps, until the comparator trips. The upper byte is then pulled back one step so that the staircase sits just below the sample. After that, the lower byte rises one step at a time until the comparator trips again. The code reached at that point is stored as the result. A conversion therefore needs at most about 512 comparisons, where a single full-range count would need 65 536.

The code is held for a programmable number of clock cycles before each comparison. This gives the DAC and comparator time to settle. The comparator bit passes through a flop synchroniser before the sequencer uses it. When the conversion ends, the staircase returns to zero, ready for the next held sample. If the sample lies above the top of the range, the result saturates at full scale and an overrange flag is raised.

Top module: `stair_adc_seq`

## Requirements
- R1: After a conversion of a sample S in the range 0 to 65535, with the comparator reporting (code >= S), the result equals S. It is the smallest 16-bit code whose staircase level reaches the sample.
- R2: While the coarse pass runs, the lower byte of the DAC code (bits 7:0) stays at zero. The upper byte (bits 15:8) only rises by one at a time. The fine pass starts only after the coarse pass has ended.
- R3: When the coarse pass trips at upper byte H, the upper byte becomes H-1, or stays 0 when H is 0. The upper byte then stays fixed for the whole fine pass. During one conversion the upper byte therefore falls exactly once when 0 < S <= 65280, and never otherwise.
- R4: If the staircase reaches code 0xFFFF without the comparator tripping, the result is 0xFFFF and the overrange flag is 1. For any in-range sample the flag is 0. The flag changes only together with the result.
- R5: The done output is high for exactly one clock cycle per conversion, in the cycle in which the result output takes its new value. The result does not change at any other time.
- R6: Whenever busy is low, the DAC code is zero.
- R7: A start pulse that arrives while busy is high has no effect. The running conversion continues without restarting and ends with a single done pulse.
- R8: Each DAC code is held for SETTLE cycles (at least SYNC_STAGES+1) before the synchronised comparator bit is acted on. A conversion keeps busy high for no more than (2*256+1)*SETTLE cycles.
- R9: After reset, busy, done, overrange, result and DAC code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a conversion of the held sample (taken only when idle) |
| cmp_i | input | 1 | Comparator, 1 when DAC output is at or above the sample (asynchronous) |
| dac_code_o | output | 16 | Staircase code to the DAC, upper byte coarse, lower byte fine |
| result_o | output | 16 | Last converted code |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| ovr_o | output | 1 | Overrange flag belonging to result_o |

## Verification
A wrong pass state or a wrong byte counter shows at the DAC port within one settle interval. Examples are a lower byte moving during the coarse pass, or an upper byte that falls twice or never. It also shows in the result as soon as done pulses, because the result no longer equals the modelled sample. A stuck or misloaded settle counter shows in the busy duration. A start that is wrongly accepted mid-conversion shows as an extra drop of the upper byte.

// File: rtl/stair_adc_pkg.sv
package stair_adc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COARSE = 2'd1,
      ST_FINE   = 2'd2
   } stair_state_e;
endpackage

// File: rtl/stair_sync.sv
module stair_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("stair_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stair_pacer.sv
module stair_pacer #(
   parameter int SETTLE = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   output logic tick_o
);
   localparam int CW = $clog2(SETTLE) + 1;
   localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (SETTLE < 2) begin : g_bad
         $error("stair_pacer: SETTLE must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (restart_i)      cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign tick_o = (cnt_q == '0);

   // R8: a freshly loaded interval never ends in the next cycle
   a_r8_settle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !tick_o);
endmodule

// File: rtl/stair_adc_seq.sv
module stair_adc_seq
   import stair_adc_pkg::*;
#(
   parameter int SEG_W       = 8,
   parameter int SETTLE      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic                 cmp_i,
   output logic [2*SEG_W-1:0]   dac_code_o,
   output logic [2*SEG_W-1:0]   result_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 ovr_o
);
   localparam int CODE_W = 2 * SEG_W;
   localparam logic [SEG_W-1:0]  SEG_MAX  = {SEG_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   generate
      if (SETTLE < SYNC_STAGES + 1) begin : g_bad_settle
         $error("stair_adc_seq: SETTLE must exceed SYNC_STAGES");
      end
      if (SEG_W < 2) begin : g_bad_seg
         $error("stair_adc_seq: SEG_W must be at least 2");
      end
   endgenerate

   stair_state_e       st_q;
   logic [SEG_W-1:0]   hi_q, lo_q;
   logic               tripped_q;
   logic [CODE_W-1:0]  result_q;
   logic               ovr_q, done_q;
   logic               cmp_s, tick, restart;

   stair_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_i),
      .q_o    (cmp_s)
   );

   stair_pacer #(.SETTLE(SETTLE)) u_pacer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .tick_o    (tick)
   );

   always_comb begin
      unique case (st_q)
         ST_IDLE: restart = start_i;
         default: restart = tick;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         hi_q      <= '0;
         lo_q      <= '0;
         tripped_q <= 1'b0;
         result_q  <= '0;
         ovr_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q      <= ST_COARSE;
                  hi_q      <= '0;
                  lo_q      <= '0;
                  tripped_q <= 1'b0;
               end
            end
            ST_COARSE: begin
               if (tick) begin
                  if (cmp_s) begin
                     tripped_q <= 1'b1;
                     hi_q      <= (hi_q == '0) ? '0 : hi_q - 1'b1;
                     st_q      <= ST_FINE;
                  end else if (hi_q == SEG_MAX) begin
                     st_q <= ST_FINE;
                  end else begin
                     hi_q <= hi_q + 1'b1;
                  end
               end
            end
            ST_FINE: begin
               if (tick) begin
                  if (cmp_s || lo_q == SEG_MAX) begin
                     if (cmp_s) begin
                        result_q <= {hi_q, lo_q};
                        ovr_q    <= 1'b0;
                     end else if (tripped_q) begin
                        result_q <= {hi_q + 1'b1, {SEG_W{1'b0}}};
                        ovr_q    <= 1'b0;
                     end else begin
                        result_q <= CODE_MAX;
                        ovr_q    <= 1'b1;
                     end
                     done_q <= 1'b1;
                     st_q   <= ST_IDLE;
                     hi_q   <= '0;
                     lo_q   <= '0;
                  end else begin
                     lo_q <= lo_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign dac_code_o = {hi_q, lo_q};
   assign result_o   = result_q;
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign ovr_o      = ovr_q;

   // R2: lower byte parked at zero during the coarse pass
   a_r2_lo_zero_coarse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_COARSE) |-> (lo_q == '0));
   // R3: upper byte frozen across the fine pass
   a_r3_hi_frozen_fine: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_FINE && $past(st_q) == ST_FINE) |-> $stable(hi_q));
   // R5: single-cycle completion strobe
   a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R5: result only moves with done
   a_r5_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));
   // R6: staircase at zero while idle
   a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (dac_code_o == '0));
   // R4: overrange always comes with a full-scale result
   a_r4_ovr_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovr_o |-> (result_o == CODE_MAX));
endmodule

// File: tb/stair_adc_seq_tb_top.sv
module stair_adc_seq_tb_top;
   localparam int SETTLE = 4;
   localparam int BUSY_MAX = (2*256 + 1) * SETTLE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [16:0] sample = '0;
   logic        cmp;
   logic [15:0] dac, result;
   logic        busy, done, ovr;

   int vectors = 0;
   int errors  = 0;

   always #2 clk = ~clk;

   assign cmp = ({1'b0, dac} >= sample);

   stair_adc_seq #(.SEG_W(8), .SETTLE(SETTLE), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
      .dac_code_o(dac), .result_o(result), .busy_o(busy),
      .done_o(done), .ovr_o(ovr)
   );

   // monitor state
   int          busy_cyc, decs, rise_bad, dones, pulse_bad;
   int          res_bad = 0, idle_bad = 0;
   logic [15:0] cap_res, prev_dac = '0, prev_res = '0;
   logic        cap_ovr, prev_busy = 1'b0, prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) begin
            busy_cyc++;
            if (prev_busy && dac[15:8] < prev_dac[15:8]) decs++;
            if (prev_busy && dac[15:8] > prev_dac[15:8] &&
                (dac[7:0] != 0 || dac[15:8] != prev_dac[15:8] + 8'd1)) rise_bad++;
         end else if (dac != 0) idle_bad++;
         if (done) begin
            dones++;
            cap_res = result;
            cap_ovr = ovr;
            if (prev_done) pulse_bad++;
         end else if (result != prev_res) res_bad++;
      end
      prev_dac  = dac;
      prev_busy = busy;
      prev_done = done;
      prev_res  = result;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_res(input int s);
      return (s > 65535) ? 65535 : s;
   endfunction

   function automatic int exp_decs(input int s);
      return (s > 0 && s <= 65280) ? 1 : 0;
   endfunction

   task automatic convert(input int s, input bit inject);
      int n;
      sample = 17'(s);
      @(negedge clk);
      busy_cyc = 0; decs = 0; rise_bad = 0; dones = 0; pulse_bad = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (dones == 0 && n < 4000) begin
         @(negedge clk);
         n++;
         if (inject && n == 12) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
         end
      end
      repeat (4) @(negedge clk);
      check(dones == 1, "R5/R7 done count", dones, 1);
      check(cap_res == 16'(exp_res(s)), "R1 result", int'(cap_res), exp_res(s));
      check(cap_ovr == (s > 65535), "R4 overrange", int'(cap_ovr), int'(s > 65535));
      check(decs == exp_decs(s), "R3 upper byte drops", decs, exp_decs(s));
      check(rise_bad == 0, "R2 coarse stepping", rise_bad, 0);
      check(pulse_bad == 0, "R5 done width", pulse_bad, 0);
      check(busy_cyc <= BUSY_MAX, "R8 busy length", busy_cyc, BUSY_MAX);
      check(!busy && dac == 0, "R6 idle staircase", int'(dac), 0);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'd2718);
      repeat (3) @(negedge clk);
      // R9 reset state
      check(!busy && !done && !ovr && result == 0 && dac == 0,
            "R9 reset state", int'(result), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && dac == 0, "R9 after release", int'(dac), 0);

      // directed corners
      convert(0, 1'b0);
      convert(1, 1'b0);
      convert(255, 1'b0);
      convert(256, 1'b0);
      convert(257, 1'b0);
      convert(32767, 1'b1);   // R7: start pulse injected mid-conversion
      convert(65280, 1'b0);
      convert(65281, 1'b0);
      convert(65534, 1'b0);
      convert(65535, 1'b0);
      convert(65536, 1'b0);   // R4 overrange
      convert(1000, 1'b0);    // flag clears after overrange

      for (int i = 0; i < 30; i++) begin
         int s;
         s = int'($urandom % 65537);
         convert(s, (s >= 2048) && (i % 3 == 0));
      end

      check(res_bad == 0, "R5 result stable without done", res_bad, 0);
      check(idle_bad == 0, "R6 nonzero code while idle", idle_bad, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule